// File: doc/BRIEF.md
# Rotated Interleaved Parity Line Code Unit

This block produces and verifies an 8-bit error detection code for a 64-byte cache line. The line arrives as four 128-bit beats, which is how it crosses a wide stacked-memory channel. For each beat, the block XORs the sixteen bytes together into one intermediate parity byte. It then rotates that byte left, circularly, by the beat's position in the line, and XOR-accumulates the result. The four rotations differ, so a stuck or flipped wire that corrupts the same bit index in every beat cannot cancel itself out in the final byte.

A transfer is marked with a valid strobe and a first-beat marker. One cycle after the fourth beat, a single-cycle done pulse presents the code. In generate mode the code is the result and the error flag stays low. In check mode the block compares the code with a stored byte that the caller supplies, and raises the error flag on any difference. The mode and the stored byte are sampled together with the fourth beat. A first-beat marker that arrives while a line is in progress abandons the partial line and starts over.

Top module: `rotparity_edc`

## Requirements
- R1: The intermediate parity of a beat is the XOR of its sixteen bytes, where byte k is bits [8k+7:8k] of the beat.
- R2: The intermediate parity of beat b (b = 0..3, counted from the first-beat marker) is rotated left by b bit positions, and bits leaving bit 7 re-enter at bit 0.
- R3: The code for a line is the XOR of its four rotated intermediate parities.
- R4: The code appears on `res_code` together with a one-cycle `res_done` pulse in the cycle after the fourth beat is accepted. `res_code` and `res_err` hold their values until the next pulse.
- R5: `chk_mode`=1 selects check mode and `chk_mode`=0 selects generate mode, both sampled with the fourth beat. In check mode `res_err` is 1 exactly when the code differs from `chk_stored` (also sampled with the fourth beat). In generate mode `res_err` is 0.
- R6: Flipping the same bit index in all four beats of a line always changes the code, so a check against the code of the clean line reports an error.
- R7: A beat with `beat_first`=1 that arrives while a line is in progress discards the partial accumulation and becomes beat 0 of a new line.
- R8: A beat with `beat_valid`=1 and `beat_first`=0 while no line is in progress is ignored. Cycles with `beat_valid`=0 inside a line do not advance it.
- R9: After a synchronous active-high reset, `res_done`, `res_code` and `res_err` are 0 and no line is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A beat is presented this cycle |
| beat_first | input | 1 | The presented beat is beat 0 of a line |
| beat_data | input | 128 | Beat payload |
| chk_mode | input | 1 | 1 = check against stored byte, 0 = generate |
| chk_stored | input | 8 | Stored code to compare with in check mode |
| res_done | output | 1 | One-cycle pulse: code and flag updated |
| res_code | output | 8 | Computed line code |
| res_err | output | 1 | Mismatch flag (check mode only) |

## Verification
The main sweep sets each of the 512 line bits alone, and the expected code is a single bit at a position computed from the byte-lane bit and the beat index. This separates the byte fold from the rotation: a wrong rotation amount or direction, or a missing wrap, moves the bit. Random lines in generate mode, and the same lines in check mode with a correct or single-bit-corrupted stored byte, exercise the accumulation and the comparator. A sweep that flips each of the 128 bit indices in all four beats at once covers the case the rotation exists for: a plain unrotated fold would let all 128 of those faults cancel. Directed sequences cover restart in the middle of a line, stray beats while idle, idle gaps inside a line, and holding of the outputs between pulses.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

  typedef enum logic {
    RPE_GENERATE = 1'b0,
    RPE_CHECK    = 1'b1
  } rpe_mode_e;

  // Rotation applied to the parity of a beat: its index, wrapped to the code width.
  function automatic int rot_amount(input int beat_idx, input int code_w);
    return beat_idx % code_w;
  endfunction

endpackage

// File: rtl/rpe_fold.sv
// First level: XOR all OUT_W-wide lanes of one beat into a single lane.
module rpe_fold #(
  parameter int IN_W  = 128,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int LANES = IN_W / OUT_W;

  logic [OUT_W-1:0] chain [LANES];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_head
        assign chain[i] = din[OUT_W-1:0];
      end else begin : g_tail
        assign chain[i] = chain[i-1] ^ din[i*OUT_W +: OUT_W];
      end
    end
  endgenerate

  assign dout = chain[LANES-1];
endmodule

// File: rtl/rpe_rotl.sv
// Circular left rotation by a run-time amount, built as a mux over every fixed rotation.
module rpe_rotl #(
  parameter int W    = 8,
  parameter int SH_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [W-1:0] cand [W];

  generate
    for (genvar k = 0; k < W; k++) begin : g_rot
      if (k == 0) begin : g_none
        assign cand[k] = din;
      end else begin : g_some
        assign cand[k] = {din[W-1-k:0], din[W-1:W-k]};
      end
    end
  endgenerate

  assign dout = cand[amt];
endmodule

// File: rtl/rpe_seq.sv
// Beat sequencer: tracks position within a line and decides which beats are accepted.
module rpe_seq #(
  parameter int BEATS = 4,
  parameter int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             first,
  output logic             accept,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  always_comb begin
    accept = valid && (first || busy_q);
    idx    = first ? '0 : cnt_q;
    last   = accept && (idx == IDX_W'(BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      if (last) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q  <= idx + 1'b1;
        busy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rotparity_edc.sv
module rotparity_edc
  import rpe_pkg::*;
#(
  parameter int BEAT_W = 128,
  parameter int CODE_W = 8,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic              beat_first,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic              chk_mode,
  input  logic [CODE_W-1:0] chk_stored,
  output logic              res_done,
  output logic [CODE_W-1:0] res_code,
  output logic              res_err
);
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int SH_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  logic             accept;
  logic             last;
  logic [IDX_W-1:0] idx;
  logic [CODE_W-1:0] folded;
  logic [CODE_W-1:0] rotated;
  logic [CODE_W-1:0] acc_q;
  logic [CODE_W-1:0] acc_next;
  logic [SH_W-1:0]   amt;
  rpe_mode_e         mode;

  rpe_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .valid  (beat_valid),
    .first  (beat_first),
    .accept (accept),
    .idx    (idx),
    .last   (last)
  );

  rpe_fold #(.IN_W(BEAT_W), .OUT_W(CODE_W)) u_fold (
    .din  (beat_data),
    .dout (folded)
  );

  always_comb begin
    amt  = SH_W'(rot_amount(int'(idx), CODE_W));
    mode = rpe_mode_e'(chk_mode);
  end

  rpe_rotl #(.W(CODE_W), .SH_W(SH_W)) u_rot (
    .din  (folded),
    .amt  (amt),
    .dout (rotated)
  );

  // A first-beat marker restarts the accumulation from zero.
  always_comb acc_next = (beat_first ? '0 : acc_q) ^ rotated;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      res_done <= 1'b0;
      res_code <= '0;
      res_err  <= 1'b0;
    end else begin
      res_done <= last;
      if (accept) acc_q <= acc_next;
      if (last) begin
        res_code <= acc_next;
        res_err  <= (mode == RPE_CHECK) && (acc_next != chk_stored);
      end
    end
  end
endmodule

// File: rtl/rpe_checker.sv
module rpe_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              beat_valid,
  input logic              chk_mode,
  input logic [CODE_W-1:0] chk_stored,
  input logic              res_done,
  input logic [CODE_W-1:0] res_code,
  input logic              res_err
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!res_done && res_code == '0 && !res_err)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done); // R4

  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    res_done |-> $past(beat_valid)); // R4

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !res_done |-> ($stable(res_code) && $stable(res_err))); // R4

  AST_GEN_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (res_done && !$past(chk_mode)) |-> !res_err); // R5

  AST_CHECK_COMPARE: assert property (@(posedge clk) disable iff (rst)
    (res_done && $past(chk_mode)) |-> (res_err == (res_code != $past(chk_stored)))); // R5
endmodule

bind rotparity_edc rpe_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .beat_valid (beat_valid),
  .chk_mode   (chk_mode),
  .chk_stored (chk_stored),
  .res_done   (res_done),
  .res_code   (res_code),
  .res_err    (res_err)
);

// File: tb/rotparity_edc_test.sv
`timescale 1ns/1ps
module rotparity_edc_test;
  localparam int BW = 128;
  localparam int CW = 8;
  localparam int NB = 4;
  localparam int LW = BW * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          beat_valid = 1'b0;
  logic          beat_first = 1'b0;
  logic [BW-1:0] beat_data = '0;
  logic          chk_mode = 1'b0;
  logic [CW-1:0] chk_stored = '0;
  logic          res_done;
  logic [CW-1:0] res_code;
  logic          res_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rotparity_edc uut (
    .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_first(beat_first),
    .beat_data(beat_data), .chk_mode(chk_mode), .chk_stored(chk_stored),
    .res_done(res_done), .res_code(res_code), .res_err(res_err)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] model(input logic [LW-1:0] line);
    logic [CW-1:0] acc = '0;
    for (int b = 0; b < NB; b++) begin
      logic [CW-1:0] p = '0;
      logic [2*CW-1:0] t;
      for (int k = 0; k < BW / CW; k++) p ^= line[b*BW + k*CW +: CW];
      t = {p, p} << (b % CW);
      acc ^= t[2*CW-1:CW];
    end
    return acc;
  endfunction

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] l;
    for (int w = 0; w < LW / 32; w++) l[w*32 +: 32] = $urandom;
    return l;
  endfunction

  task automatic partial(input logic [LW-1:0] line, input int n);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      beat_valid = 1'b1; beat_first = (b == 0); beat_data = line[b*BW +: BW];
    end
  endtask

  task automatic run_line(input logic [LW-1:0] line, input bit mode,
                          input logic [CW-1:0] stored, input int gap,
                          output logic [CW-1:0] code, output logic err, output logic done);
    for (int b = 0; b < NB; b++) begin
      if (b > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); beat_valid = 1'b0; beat_first = 1'b0;
        end
      end
      @(negedge clk);
      beat_valid = 1'b1; beat_first = (b == 0); beat_data = line[b*BW +: BW];
      chk_mode = mode; chk_stored = stored;
    end
    @(negedge clk);
    beat_valid = 1'b0; beat_first = 1'b0;
    done = res_done; code = res_code; err = res_err;
  endtask

  task automatic expect_line(input string req, input logic [LW-1:0] line, input bit mode,
                             input logic [CW-1:0] stored, input int gap,
                             input logic [CW-1:0] exp_code, input logic exp_err);
    logic [CW-1:0] c; logic e; logic d;
    run_line(line, mode, stored, gap, c, e, d);
    check_eq(req, "done pulse", 32'(d), 32'(1));
    check_eq(req, "code", 32'(c), 32'(exp_code));
    check_eq(req, "err", 32'(e), 32'(exp_err));
  endtask

  initial begin
    logic [LW-1:0] line, base, mask, other;
    logic [CW-1:0] ref_code;

    // R9: reset state
    repeat (3) @(negedge clk);
    check_eq("R9", "done in reset", 32'(res_done), 32'(0));
    check_eq("R9", "code in reset", 32'(res_code), 32'(0));
    check_eq("R9", "err in reset", 32'(res_err), 32'(0));
    rst = 1'b0;
    @(negedge clk);
    check_eq("R9", "done after reset", 32'(res_done), 32'(0));

    // R3: all-zero line
    expect_line("R3", '0, 1'b0, 8'h00, 0, 8'h00, 1'b0);

    // R1: one nonzero byte in beat 0 at each byte lane
    for (int k = 0; k < BW / CW; k++) begin
      line = '0; line[k*CW +: CW] = 8'hA5;
      expect_line("R1", line, 1'b0, 8'h00, 0, 8'hA5, 1'b0);
    end

    // R2: every single-bit line; expected bit = (lane bit + beat) mod 8
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < BW; j++) begin
        logic [CW-1:0] e;
        line = '0; line[b*BW + j] = 1'b1;
        e = 8'h01 << (((j % CW) + b) % CW);
        expect_line("R2", line, 1'b0, 8'h00, 0, e, 1'b0);
      end
    end

    // R3 / R5: random lines, generate mode, stored byte deliberately wrong
    for (int i = 0; i < 40; i++) begin
      line = rand_line();
      ref_code = model(line);
      expect_line("R3", line, 1'b0, ~ref_code, 0, ref_code, 1'b0);
    end

    // R5: check mode, correct stored byte and each single-bit corruption of it
    for (int i = 0; i < 10; i++) begin
      line = rand_line();
      ref_code = model(line);
      expect_line("R5", line, 1'b1, ref_code, 0, ref_code, 1'b0);
      for (int k = 0; k < CW; k++)
        expect_line("R5", line, 1'b1, ref_code ^ (8'h01 << k), 0, ref_code, 1'b1);
    end

    // R6: same bit index flipped in all four beats must mismatch the clean code
    base = rand_line();
    ref_code = model(base);
    for (int t = 0; t < BW; t++) begin
      mask = '0;
      for (int b = 0; b < NB; b++) mask[b*BW + t] = 1'b1;
      line = base ^ mask;
      expect_line("R6", line, 1'b1, ref_code, 0, model(line), 1'b1);
    end

    // R4: pulse is one cycle wide, outputs hold, gaps inside a line do not advance it
    line = rand_line();
    ref_code = model(line);
    expect_line("R4", line, 1'b0, 8'h00, 2, ref_code, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_eq("R4", "done low after pulse", 32'(res_done), 32'(0));
      check_eq("R4", "code held", 32'(res_code), 32'(ref_code));
    end

    // R7: restart after two and after three beats
    for (int n = 2; n <= 3; n++) begin
      other = rand_line();
      line = rand_line();
      partial(other, n);
      expect_line("R7", line, 1'b0, 8'h00, 0, model(line), 1'b0);
    end

    // R8: stray beats while idle give no pulse and do not disturb the next line
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      beat_valid = 1'b1; beat_first = 1'b0; beat_data = {4{32'hDEADBEEF}};
    end
    @(negedge clk); beat_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin
      check_eq("R8", "no pulse from stray beats", 32'(res_done), 32'(0));
      @(negedge clk);
    end
    line = rand_line();
    expect_line("R8", line, 1'b0, 8'h00, 1, model(line), 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule